// File: doc/BRIEF.md
# Byte-Serial 8086 Instruction Decoder

This block takes 8086 machine code one byte at a time over a valid/ready input and produces one decoded record for each complete instruction. The decode is incremental. Prefix bytes are folded into held state. The opcode byte selects an operation and a format. A ModRM byte, when the format has one, picks the operands and sets how many displacement bytes follow. Immediate or displacement bytes are then counted off until the instruction is complete.

Each record is presented for one cycle. It gives:
- an operation code;
- a word/byte size flag;
- source and destination operand selectors;
- the segment-override, lock and repeat prefix state;
- the total number of bytes the instruction used.

An opcode the block does not handle produces an invalid record, and the decoder starts again on the next byte. The block does not execute instructions and does not compute effective addresses.

The supported opcodes are:
- the eight two-operand ALU rows;
- register INC, DEC, PUSH and POP;
- the sixteen conditional jumps;
- register/memory MOV and immediate MOV;
- XCHG with AX;
- segment push and pop;
- the no-operand opcodes.

Top module: `i86_byte_decoder`

## Requirements
- R1: While `rst` is high, `out_valid` and `in_ready` are low. From the first cycle after `rst` falls, `in_ready` is high and stays high, and `out_valid` stays low until a byte is accepted.
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. A cycle with `in_valid` low changes no decode state. The record for an instruction shows `out_valid` high in the cycle after its last byte is taken, for that one cycle only.
- R3: Prefix bytes set held state and do not post a record. 0x26/0x2E/0x36/0x3E set `out_seg_en`=1 and `out_seg` to 0/1/2/3 (ES/CS/SS/DS). 0xF0 sets `out_lock`. 0xF2 sets `out_rep`=2 and 0xF3 sets `out_rep`=3; 0 means no repeat. When a kind repeats, the later byte wins. All prefix state clears after each record.
- R4: For an opcode row base B = 8·k with k from 0 to 7 (ADD, OR, ADC, SBB, AND, SUB, XOR, CMP), the operation code is k. B+0 and B+1 are byte/word r/m←reg forms, and B+2 and B+3 are byte/word reg←r/m forms, all followed by a ModRM byte. B+4 is AL←imm8 (source 1, destination 10, byte). B+5 is AX←imm16 (source 1, destination 2, word).
- R5: Operand codes are: 0 none, 1 immediate, 2+i word register i (AX, CX, DX, BX, SP, BP, SI, DI), 10+i byte register i (AL, CL, DL, BL, AH, CH, DH, BH), 18+s segment s (ES, CS, SS, DS). In a ModRM byte, the fields are mod = bits 7:6, reg = bits 5:3 and rm = bits 2:0. reg always names a register. When mod=3, rm also names a register. Both use the word or byte table according to `out_word`.
- R6: For mod 0 to 2, rm names a memory operand 22+rm ([BX+SI], [BX+DI], [BP+SI], [BP+DI], [SI], [DI], [BP], [BX]). The exception is mod=0 with rm=6, which is code 30 (direct address) followed by 2 bytes. Otherwise mod=0 adds 0 bytes, mod=1 adds 1 byte and mod=2 adds 2 bytes.
- R7: The MOV forms 0x88 to 0x8B use operation 12. For r/m←reg forms, source is the reg operand and destination is the rm operand. For reg←r/m forms (row offsets 2 and 3, and 0x8A/0x8B) the two are swapped.
- R8: Opcodes 0x40 to 0x5F are INC (8), DEC (9), PUSH (10) and POP (11) in groups of eight. Source and destination are both word register opcode[2:0]. They are word-sized and have length 1 plus prefixes.
- R9: Opcodes 0x70 to 0x7F give operation 16+opcode[3:0]. Source is 1, destination is 0 and the size is byte. One displacement byte follows.
- R10: Opcodes 0xB0 to 0xB7 are MOV (12) of imm8 into byte register opcode[2:0], with one byte following. Opcodes 0xB8 to 0xBF are MOV of imm16 into word register opcode[2:0], with two bytes following. Source is 1 in both cases.
- R11: The complete one-byte opcodes are as follows; those with no operands have source 0, destination 0 and byte size.
  - 0x90 is NOP (14).
  - 0x91 to 0x97 are XCHG (13) with source AX (2), destination word register opcode[2:0] and word size.
  - 0x06, 0x0E, 0x16 and 0x1E are PUSH (10), and 0x07, 0x17 and 0x1F are POP (11). Their source is segment opcode[4:3], their destination is 0 and the size is word.
  - 0x27, 0x2F, 0x37 and 0x3F are operations 32 to 35.
  - 0x98 is 36 and 0x99 is 37.
  - 0x9B to 0x9F are 38 to 42.
  - 0xC3 is 43 and 0xCB is 44.
- R12: Any other opcode byte posts a record with `out_bad`=1 and operation 63. That record has source 0, destination 0, size 0 and all prefix fields 0. Its length counts the bytes up to and including the bad opcode. The next byte is decoded as a fresh instruction.
- R13: `out_len` is the count of prefix, opcode, ModRM, displacement and immediate bytes in the instruction, modulo 2^LEN_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Machine-code byte |
| out_valid | output | 1 | Record valid for this cycle |
| out_bad | output | 1 | Record is an invalid opcode |
| out_op | output | 6 | Operation code |
| out_word | output | 1 | 1 = word size, 0 = byte size |
| out_src | output | 5 | Source operand code |
| out_dst | output | 5 | Destination operand code |
| out_seg_en | output | 1 | A segment override is present |
| out_seg | output | 2 | Override segment |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat prefix kind |
| out_len | output | LEN_W | Instruction length in bytes |

## Verification
The hardest situations to reach are a multi-byte instruction whose bytes are separated by idle cycles, and the direct-address ModRM case, where mod=0 still adds two bytes. Prefix state also has to survive such gaps and then clear before the next instruction. The stimulus therefore inserts an idle cycle every seventh slot, so that gaps fall at every point inside instructions. It also sweeps all 32 mod/rm combinations behind a prefix-free MOV, and then runs prefix chains ahead of both valid and invalid opcodes.

// File: rtl/i86dec_pkg.sv
package i86dec_pkg;
  localparam int OP_W   = 6;
  localparam int SEL_W  = 5;
  localparam int PEND_W = 2;

  typedef enum logic [1:0] {PH_OPC = 2'd0, PH_MODRM = 2'd1, PH_OPND = 2'd2} phase_t;
  typedef enum logic [2:0] {K_BAD, K_SEG, K_LOCK, K_REP, K_DONE, K_MODRM, K_IMM} kind_t;

  localparam logic [OP_W-1:0] OP_INC  = 6'd8;
  localparam logic [OP_W-1:0] OP_PUSH = 6'd10;
  localparam logic [OP_W-1:0] OP_POP  = 6'd11;
  localparam logic [OP_W-1:0] OP_MOV  = 6'd12;
  localparam logic [OP_W-1:0] OP_XCHG = 6'd13;
  localparam logic [OP_W-1:0] OP_NOP  = 6'd14;
  localparam logic [OP_W-1:0] OP_JCC  = 6'd16;
  localparam logic [OP_W-1:0] OP_DAA  = 6'd32;
  localparam logic [OP_W-1:0] OP_CBW  = 6'd36;
  localparam logic [OP_W-1:0] OP_CWD  = 6'd37;
  localparam logic [OP_W-1:0] OP_WAIT = 6'd38;
  localparam logic [OP_W-1:0] OP_RETN = 6'd43;
  localparam logic [OP_W-1:0] OP_RETF = 6'd44;
  localparam logic [OP_W-1:0] OP_BAD  = 6'd63;

  localparam logic [SEL_W-1:0] S_NONE   = 5'd0;
  localparam logic [SEL_W-1:0] S_IMM    = 5'd1;
  localparam logic [SEL_W-1:0] S_WREG   = 5'd2;
  localparam logic [SEL_W-1:0] S_BREG   = 5'd10;
  localparam logic [SEL_W-1:0] S_SREG   = 5'd18;
  localparam logic [SEL_W-1:0] S_MEM    = 5'd22;
  localparam logic [SEL_W-1:0] S_DIRECT = 5'd30;

  typedef struct packed {
    kind_t             kind;
    logic [OP_W-1:0]   op;
    logic              word;
    logic              swap;
    logic [SEL_W-1:0]  src;
    logic [SEL_W-1:0]  dst;
    logic [PEND_W-1:0] nimm;
  } opc_info_t;

  function automatic logic [SEL_W-1:0] sel_at(input logic [SEL_W-1:0] base, input logic [2:0] idx);
    return base + SEL_W'(idx);
  endfunction

  function automatic logic [OP_W-1:0] op_at(input logic [OP_W-1:0] base, input logic [3:0] idx);
    return base + OP_W'(idx);
  endfunction
endpackage

// File: rtl/i86_opcode_lut.sv
module i86_opcode_lut
  import i86dec_pkg::*;
(
  input  logic [7:0] opc,
  output opc_info_t  info
);
  logic [2:0] row;
  logic [2:0] low;

  assign row = opc[5:3];
  assign low = opc[2:0];

  always_comb begin
    info      = '0;
    info.kind = K_BAD;
    info.op   = OP_BAD;
    info.src  = S_NONE;
    info.dst  = S_NONE;
    if (opc[7:6] == 2'b00) begin
      case (low)
        3'd0, 3'd1, 3'd2, 3'd3: begin
          info.kind = K_MODRM;
          info.op   = op_at('0, {1'b0, row});
          info.word = low[0];
          info.swap = low[1];
        end
        3'd4: begin
          info.kind = K_IMM;
          info.op   = op_at('0, {1'b0, row});
          info.nimm = PEND_W'(1);
          info.src  = S_IMM;
          info.dst  = S_BREG;
        end
        3'd5: begin
          info.kind = K_IMM;
          info.op   = op_at('0, {1'b0, row});
          info.nimm = PEND_W'(2);
          info.word = 1'b1;
          info.src  = S_IMM;
          info.dst  = S_WREG;
        end
        3'd6: begin
          if (!row[2]) begin
            info.kind = K_DONE;
            info.op   = OP_PUSH;
            info.word = 1'b1;
            info.src  = sel_at(S_SREG, {1'b0, row[1:0]});
          end else begin
            info.kind = K_SEG;
          end
        end
        default: begin
          if (!row[2]) begin
            if (row != 3'd1) begin
              info.kind = K_DONE;
              info.op   = OP_POP;
              info.word = 1'b1;
              info.src  = sel_at(S_SREG, {1'b0, row[1:0]});
            end
          end else begin
            info.kind = K_DONE;
            info.op   = op_at(OP_DAA, {2'b00, row[1:0]});
          end
        end
      endcase
    end else if (opc[7:5] == 3'b010) begin
      info.kind = K_DONE;
      info.op   = op_at(OP_INC, {2'b00, opc[4:3]});
      info.word = 1'b1;
      info.src  = sel_at(S_WREG, low);
      info.dst  = sel_at(S_WREG, low);
    end else if (opc[7:4] == 4'h7) begin
      info.kind = K_IMM;
      info.op   = op_at(OP_JCC, opc[3:0]);
      info.nimm = PEND_W'(1);
      info.src  = S_IMM;
    end else if (opc[7:2] == 6'b100010) begin
      info.kind = K_MODRM;
      info.op   = OP_MOV;
      info.word = opc[0];
      info.swap = opc[1];
    end else if (opc[7:3] == 5'b10010) begin
      info.kind = K_DONE;
      if (low == 3'd0) begin
        info.op = OP_NOP;
      end else begin
        info.op   = OP_XCHG;
        info.word = 1'b1;
        info.src  = S_WREG;
        info.dst  = sel_at(S_WREG, low);
      end
    end else if (opc[7:3] == 5'b10011) begin
      case (low)
        3'd0: begin info.kind = K_DONE; info.op = OP_CBW; end
        3'd1: begin info.kind = K_DONE; info.op = OP_CWD; end
        3'd2: ;
        default: begin
          info.kind = K_DONE;
          info.op   = op_at(OP_WAIT, {1'b0, low - 3'd3});
        end
      endcase
    end else if (opc[7:4] == 4'hB) begin
      info.kind = K_IMM;
      info.op   = OP_MOV;
      info.word = opc[3];
      info.nimm = opc[3] ? PEND_W'(2) : PEND_W'(1);
      info.src  = S_IMM;
      info.dst  = opc[3] ? sel_at(S_WREG, low) : sel_at(S_BREG, low);
    end else begin
      case (opc)
        8'hC3:        begin info.kind = K_DONE; info.op = OP_RETN; end
        8'hCB:        begin info.kind = K_DONE; info.op = OP_RETF; end
        8'hF0:        info.kind = K_LOCK;
        8'hF2, 8'hF3: info.kind = K_REP;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i86_modrm_dec.sv
module i86_modrm_dec
  import i86dec_pkg::*;
(
  input  logic [7:0]        modrm,
  input  logic              word,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [SEL_W-1:0]  rm_sel,
  output logic [PEND_W-1:0] disp_n
);
  logic [1:0] md;
  logic [2:0] rg;
  logic [2:0] rm;

  assign md = modrm[7:6];
  assign rg = modrm[5:3];
  assign rm = modrm[2:0];

  assign reg_sel = word ? sel_at(S_WREG, rg) : sel_at(S_BREG, rg);

  always_comb begin
    case (md)
      2'd0: begin
        if (rm == 3'd6) begin
          rm_sel = S_DIRECT;
          disp_n = PEND_W'(2);
        end else begin
          rm_sel = sel_at(S_MEM, rm);
          disp_n = '0;
        end
      end
      2'd1: begin
        rm_sel = sel_at(S_MEM, rm);
        disp_n = PEND_W'(1);
      end
      2'd2: begin
        rm_sel = sel_at(S_MEM, rm);
        disp_n = PEND_W'(2);
      end
      default: begin
        rm_sel = word ? sel_at(S_WREG, rm) : sel_at(S_BREG, rm);
        disp_n = '0;
      end
    endcase
  end
endmodule

// File: rtl/i86_byte_decoder.sv
module i86_byte_decoder
  import i86dec_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic             out_bad,
  output logic [OP_W-1:0]  out_op,
  output logic             out_word,
  output logic [SEL_W-1:0] out_src,
  output logic [SEL_W-1:0] out_dst,
  output logic             out_seg_en,
  output logic [1:0]       out_seg,
  output logic             out_lock,
  output logic [1:0]       out_rep,
  output logic [LEN_W-1:0] out_len
);
  opc_info_t         info;
  logic [SEL_W-1:0]  m_reg, m_rm;
  logic [PEND_W-1:0] m_disp;

  phase_t            phase_q, phase_d;
  logic              lock_q, lock_d, segen_q, segen_d, word_q, word_d, swap_q, swap_d;
  logic [1:0]        rep_q, rep_d, seg_q, seg_d;
  logic [LEN_W-1:0]  len_q, len_d, len_inc;
  logic [OP_W-1:0]   op_q, op_d, p_op;
  logic [SEL_W-1:0]  src_q, src_d, dst_q, dst_d, p_src, p_dst;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              p_word, post, post_bad, take, ready_q;

  i86_opcode_lut u_lut (
    .opc  (in_byte),
    .info (info)
  );

  i86_modrm_dec u_modrm (
    .modrm   (in_byte),
    .word    (word_q),
    .reg_sel (m_reg),
    .rm_sel  (m_rm),
    .disp_n  (m_disp)
  );

  assign take    = in_valid && ready_q;
  assign len_inc = len_q + LEN_W'(1);

  always_comb begin
    phase_d  = phase_q;
    lock_d   = lock_q;
    segen_d  = segen_q;
    seg_d    = seg_q;
    rep_d    = rep_q;
    len_d    = len_q;
    op_d     = op_q;
    word_d   = word_q;
    swap_d   = swap_q;
    src_d    = src_q;
    dst_d    = dst_q;
    pend_d   = pend_q;
    post     = 1'b0;
    post_bad = 1'b0;
    p_op     = op_q;
    p_word   = word_q;
    p_src    = src_q;
    p_dst    = dst_q;
    if (take) begin
      len_d = len_inc;
      case (phase_q)
        PH_OPC: begin
          case (info.kind)
            K_SEG: begin
              segen_d = 1'b1;
              seg_d   = in_byte[4:3];
            end
            K_LOCK: lock_d = 1'b1;
            K_REP:  rep_d  = {1'b1, in_byte[0]};
            K_DONE: begin
              post   = 1'b1;
              p_op   = info.op;
              p_word = info.word;
              p_src  = info.src;
              p_dst  = info.dst;
            end
            K_MODRM: begin
              op_d    = info.op;
              word_d  = info.word;
              swap_d  = info.swap;
              phase_d = PH_MODRM;
            end
            K_IMM: begin
              op_d    = info.op;
              word_d  = info.word;
              src_d   = info.src;
              dst_d   = info.dst;
              pend_d  = info.nimm;
              phase_d = PH_OPND;
            end
            default: begin
              post     = 1'b1;
              post_bad = 1'b1;
            end
          endcase
        end
        PH_MODRM: begin
          src_d = swap_q ? m_rm : m_reg;
          dst_d = swap_q ? m_reg : m_rm;
          if (m_disp == '0) begin
            post  = 1'b1;
            p_src = swap_q ? m_rm : m_reg;
            p_dst = swap_q ? m_reg : m_rm;
          end else begin
            pend_d  = m_disp;
            phase_d = PH_OPND;
          end
        end
        PH_OPND: begin
          if (pend_q == PEND_W'(1)) post = 1'b1;
          else pend_d = pend_q - PEND_W'(1);
        end
        default: phase_d = PH_OPC;
      endcase
    end
    if (post) begin
      phase_d = PH_OPC;
      lock_d  = 1'b0;
      segen_d = 1'b0;
      seg_d   = '0;
      rep_d   = '0;
      len_d   = '0;
      op_d    = '0;
      word_d  = 1'b0;
      swap_d  = 1'b0;
      src_d   = S_NONE;
      dst_d   = S_NONE;
      pend_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_OPC;
      lock_q     <= 1'b0;
      segen_q    <= 1'b0;
      seg_q      <= '0;
      rep_q      <= '0;
      len_q      <= '0;
      op_q       <= '0;
      word_q     <= 1'b0;
      swap_q     <= 1'b0;
      src_q      <= S_NONE;
      dst_q      <= S_NONE;
      pend_q     <= '0;
      ready_q    <= 1'b0;
      out_valid  <= 1'b0;
      out_bad    <= 1'b0;
      out_op     <= '0;
      out_word   <= 1'b0;
      out_src    <= S_NONE;
      out_dst    <= S_NONE;
      out_seg_en <= 1'b0;
      out_seg    <= '0;
      out_lock   <= 1'b0;
      out_rep    <= '0;
      out_len    <= '0;
    end else begin
      phase_q   <= phase_d;
      lock_q    <= lock_d;
      segen_q   <= segen_d;
      seg_q     <= seg_d;
      rep_q     <= rep_d;
      len_q     <= len_d;
      op_q      <= op_d;
      word_q    <= word_d;
      swap_q    <= swap_d;
      src_q     <= src_d;
      dst_q     <= dst_d;
      pend_q    <= pend_d;
      ready_q   <= 1'b1;
      out_valid <= post;
      if (post) begin
        out_bad    <= post_bad;
        out_op     <= post_bad ? OP_BAD : p_op;
        out_word   <= post_bad ? 1'b0 : p_word;
        out_src    <= post_bad ? S_NONE : p_src;
        out_dst    <= post_bad ? S_NONE : p_dst;
        out_seg_en <= post_bad ? 1'b0 : segen_q;
        out_seg    <= post_bad ? 2'd0 : seg_q;
        out_lock   <= post_bad ? 1'b0 : lock_q;
        out_rep    <= post_bad ? 2'd0 : rep_q;
        out_len    <= len_inc;
      end
    end
  end

  assign in_ready = ready_q;
endmodule

// File: rtl/i86_byte_decoder_chk.sv
module i86_byte_decoder_chk
  import i86dec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_bad,
  input logic [OP_W-1:0]  out_op,
  input logic             out_word,
  input logic [SEL_W-1:0] out_src,
  input logic [SEL_W-1:0] out_dst,
  input logic             out_seg_en,
  input logic             out_lock,
  input logic [1:0]       out_rep
);
  logic src_b, dst_b, src_w, dst_w;
  assign src_b = (out_src >= S_BREG) && (out_src < S_SREG);
  assign dst_b = (out_dst >= S_BREG) && (out_dst < S_SREG);
  assign src_w = (out_src >= S_WREG) && (out_src < S_BREG);
  assign dst_w = (out_dst >= S_WREG) && (out_dst < S_BREG);

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_post_needs_byte_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));

  p_rep_code_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rep != 2'd1));

  p_word_regs_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_word) |-> (!src_b && !dst_b));

  p_byte_regs_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bad && !out_word) |-> (!src_w && !dst_w));

  p_jump_shape_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bad && out_op[5:4] == 2'b01) |->
      (out_src == S_IMM && out_dst == S_NONE && !out_word));

  p_bad_record_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bad) |->
      (out_op == OP_BAD && out_src == S_NONE && out_dst == S_NONE &&
       !out_lock && !out_seg_en && out_rep == 2'd0));
endmodule

bind i86_byte_decoder i86_byte_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_bad    (out_bad),
  .out_op     (out_op),
  .out_word   (out_word),
  .out_src    (out_src),
  .out_dst    (out_dst),
  .out_seg_en (out_seg_en),
  .out_lock   (out_lock),
  .out_rep    (out_rep)
);

// File: tb/i86_byte_decoder_tb.sv
module i86_byte_decoder_tb;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic             in_ready, out_valid, out_bad, out_word, out_seg_en, out_lock;
  logic [5:0]       out_op;
  logic [4:0]       out_src, out_dst;
  logic [1:0]       out_seg, out_rep;
  logic [LEN_W-1:0] out_len;

  i86_byte_decoder #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_bad(out_bad), .out_op(out_op), .out_word(out_word),
    .out_src(out_src), .out_dst(out_dst), .out_seg_en(out_seg_en), .out_seg(out_seg),
    .out_lock(out_lock), .out_rep(out_rep), .out_len(out_len)
  );

  always #10 clk = ~clk;

  typedef struct {
    int bad, op, word, src, dst, segen, seg, lock, rep, len;
  } rec_t;

  int   n_chk = 0;
  int   n_bad = 0;
  int   stim[$];
  int   cur[$];
  rec_t expr;
  bit   exp_v = 0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic put(input int b);
    stim.push_back(b & 255);
  endtask

  function automatic int disp_of(input int m);
    int md = m / 64;
    int rm = m % 8;
    if (md == 1) return 1;
    if (md == 2) return 2;
    if (md == 0 && rm == 6) return 2;
    return 0;
  endfunction

  function automatic void judge(input int q[$], output bit done, output rec_t r);
    int i, need, kind, nimm, swap, b, row, off, m, md, rg, rm, regop, rmop;
    r = '{default: 0};
    done = 0; i = 0; kind = 0; nimm = 0; swap = 0;
    while (i < q.size()) begin
      b = q[i];
      if (b == 'h26 || b == 'h2e || b == 'h36 || b == 'h3e) begin r.segen = 1; r.seg = (b / 8) % 4; end
      else if (b == 'hf0) r.lock = 1;
      else if (b == 'hf2) r.rep = 2;
      else if (b == 'hf3) r.rep = 3;
      else break;
      i++;
    end
    if (i >= q.size()) return;
    b = q[i];
    if (b < 'h40) begin
      row = b / 8; off = b % 8;
      if (off < 4) begin kind = 2; r.op = row; r.word = off % 2; swap = (off >= 2); end
      else if (off == 4) begin kind = 3; nimm = 1; r.op = row; r.src = 1; r.dst = 10; end
      else if (off == 5) begin kind = 3; nimm = 2; r.op = row; r.word = 1; r.src = 1; r.dst = 2; end
      else if (off == 6) begin kind = 1; r.op = 10; r.word = 1; r.src = 18 + row; end
      else if (row == 1) kind = 0;
      else if (row < 4) begin kind = 1; r.op = 11; r.word = 1; r.src = 18 + row; end
      else begin kind = 1; r.op = 32 + row - 4; end
    end else if (b < 'h60) begin
      kind = 1; r.op = 8 + (b - 'h40) / 8; r.word = 1; r.src = 2 + b % 8; r.dst = 2 + b % 8;
    end else if (b >= 'h70 && b <= 'h7f) begin
      kind = 3; nimm = 1; r.op = 16 + b % 16; r.src = 1;
    end else if (b >= 'h88 && b <= 'h8b) begin
      kind = 2; r.op = 12; r.word = b % 2; swap = (b >= 'h8a);
    end else if (b == 'h90) begin kind = 1; r.op = 14;
    end else if (b >= 'h91 && b <= 'h97) begin kind = 1; r.op = 13; r.word = 1; r.src = 2; r.dst = 2 + b % 8;
    end else if (b == 'h98) begin kind = 1; r.op = 36;
    end else if (b == 'h99) begin kind = 1; r.op = 37;
    end else if (b >= 'h9b && b <= 'h9f) begin kind = 1; r.op = 38 + b - 'h9b;
    end else if (b >= 'hb0 && b <= 'hbf) begin
      kind = 3; r.op = 12; r.src = 1;
      if (b >= 'hb8) begin r.word = 1; nimm = 2; r.dst = 2 + b % 8; end
      else begin nimm = 1; r.dst = 10 + b % 8; end
    end else if (b == 'hc3) begin kind = 1; r.op = 43;
    end else if (b == 'hcb) begin kind = 1; r.op = 44;
    end else kind = 0;
    if (kind == 0) begin
      done = 1;
      r = '{default: 0};
      r.bad = 1; r.op = 63; r.len = (i + 1) % 16;
      return;
    end
    need = i + 1;
    if (kind == 2) begin
      if (q.size() <= need) return;
      m = q[need]; md = m / 64; rg = (m / 8) % 8; rm = m % 8;
      regop = r.word ? 2 + rg : 10 + rg;
      if (md == 3) rmop = r.word ? 2 + rm : 10 + rm;
      else if (md == 0 && rm == 6) rmop = 30;
      else rmop = 22 + rm;
      r.src = swap ? rmop : regop;
      r.dst = swap ? regop : rmop;
      need += 1 + disp_of(m);
    end
    if (kind == 3) need += nimm;
    if (q.size() < need) return;
    done = 1;
    r.len = need % 16;
  endfunction

  function automatic string cls_tag(input rec_t r);
    if (r.bad != 0) return "R12";
    if (r.op < 8) return "R4";
    if (r.op < 12) return (r.src >= 18 && r.src <= 21) ? "R11" : "R8";
    if (r.op == 12) return (r.src == 1) ? "R10" : "R7";
    if (r.op >= 16 && r.op < 32) return "R9";
    return "R11";
  endfunction

  function automatic string opnd_tag(input rec_t r);
    if (r.src >= 22 || r.dst >= 22) return "R6";
    if ((r.op < 8 || r.op == 12) && r.src != 1 && r.bad == 0) return "R5";
    return cls_tag(r);
  endfunction

  task automatic compare();
    chk("R2", "out_valid", int'(out_valid), int'(exp_v));
    if (exp_v && out_valid) begin
      chk("R12", "out_bad", int'(out_bad), expr.bad);
      chk(cls_tag(expr), "out_op", int'(out_op), expr.op);
      chk(cls_tag(expr), "out_word", int'(out_word), expr.word);
      chk(opnd_tag(expr), "out_src", int'(out_src), expr.src);
      chk(opnd_tag(expr), "out_dst", int'(out_dst), expr.dst);
      chk("R3", "out_seg_en", int'(out_seg_en), expr.segen);
      chk("R3", "out_seg", int'(out_seg), expr.seg);
      chk("R3", "out_lock", int'(out_lock), expr.lock);
      chk("R3", "out_rep", int'(out_rep), expr.rep);
      chk("R13", "out_len", int'(out_len), expr.len);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int idx, g, m;
    bit dn;
    rec_t r;
    // ALU rows: all four ModRM forms and both immediate forms (R4, R5, R6, R7)
    for (int row = 0; row < 8; row++) begin
      for (int off = 0; off < 4; off++) begin
        m = ((row % 4) * 64) + (((row + off) % 8) * 8) + ((row * 3 + off) % 8);
        put(row * 8 + off); put(m);
        for (int d = 0; d < disp_of(m); d++) put('h5a + d);
      end
      put(row * 8 + 4); put('h11);
      put(row * 8 + 5); put('h22); put('h33);
    end
    // full mod/rm sweep on word reg<-r/m MOV (R6, R7)
    for (int mm = 0; mm < 32; mm++) begin
      m = (mm / 8) * 64 + ((mm % 8) * 8) + (mm % 8);
      put('h8b); put(m);
      for (int d = 0; d < disp_of(m); d++) put('hc3);
    end
    put('h88); put('h06); put('h00); put('h10);   // direct address (R6)
    put('h8a); put('h4e); put('hf0);              // MOV CL,[BP+d8] (R7)
    // register INC/DEC/PUSH/POP (R8)
    put('h43); put('h4f); put('h52); put('h5c); put('h40); put('h5f);
    // jumps (R9)
    for (int j = 0; j < 16; j++) begin put('h70 + j); put(j * 7); end
    // immediate MOV (R10)
    put('hb4); put('h12); put('hbf); put('h34); put('h12); put('hb0); put('h01); put('hb8); put('hff); put('hff);
    // implied and XCHG (R11)
    put('h90); put('h91); put('h97); put('h06); put('h07); put('h0e); put('h16); put('h17);
    put('h1e); put('h1f); put('h27); put('h2f); put('h37); put('h3f); put('h98); put('h99);
    put('h9b); put('h9c); put('h9d); put('h9e); put('h9f); put('hc3); put('hcb);
    // prefixes (R3), then a plain instruction showing they cleared
    put('h26); put('hf0); put('hf3); put('h89); put('h07);
    put('h90);
    put('h2e); put('hf2); put('h36); put('hf3); put('h03); put('hc1);
    put('h3e); put('h27);
    put('h91);
    // invalid opcodes (R12), with prefixes ahead of one
    put('h0f); put('h60); put('h80); put('hff); put('h9a); put('hd0);
    put('h2e); put('hf2); put('h36); put('ha4);
    put('h90);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "out_valid after reset", int'(out_valid), 0);

    idx = 0; g = 0;
    while (idx < stim.size()) begin
      @(negedge clk);
      compare();
      exp_v = 0;
      if (g % 7 == 3) begin
        in_valid = 1'b0;
        in_byte  = 8'h40;
      end else begin
        in_valid = 1'b1;
        in_byte  = stim[idx][7:0];
        if (in_ready) begin
          cur.push_back(stim[idx]);
          judge(cur, dn, r);
          if (dn) begin
            expr  = r;
            exp_v = 1;
            cur.delete();
          end
          idx++;
        end
      end
      g++;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      compare();
      exp_v = 0;
      in_valid = 1'b0;
    end
    summary();
    $finish;
  end
endmodule